// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This combinational unit forms the second source operand of a 32-bit data-processing operation, together with the carry-out of the shifter. It takes a register value, a two-bit shift type and a shift amount. The amount comes either from a five-bit field encoded in the instruction or from the low eight bits of a second register. It also takes the current carry flag. In a separate mode the operand is built from an eight-bit constant that is rotated right by twice a four-bit rotate field. In that mode the shifted-register path is not used.

The amount encodings carry special meanings. A zero immediate amount means a shift by the full width for the right shifts, and a one-bit rotate through carry for rotate. A register amount of the full width or more saturates according to rules that depend on the shift type. The outputs feed the ALU operand mux and the carry-flag update logic directly.

Top module: `shifter_operand_unit`

## Requirements
- R1: `shift_type_i` encodes 0 as logical left, 1 as logical right, 2 as arithmetic right and 3 as rotate right. With `amt_from_reg_i`=0, `rot_imm_en_i`=0 and `imm_amt_i` in 1..31, the operand is `value_i` shifted or rotated by that amount, and `carry_o` is the last bit shifted out (for rotate, bit `imm_amt_i`-1 of the input).
- R2: In immediate-amount mode, a logical left shift by 0 gives `operand_o`=`value_i` and `carry_o`=`carry_i`.
- R3: In immediate-amount mode, a logical right shift by 0 acts as a shift by 32: the operand is 0 and `carry_o` is `value_i[31]`.
- R4: In immediate-amount mode, an arithmetic right shift by 0 acts as a shift by 32: every operand bit and `carry_o` equal `value_i[31]`.
- R5: In immediate-amount mode, a rotate by 0 is a one-bit rotate through carry: the operand is {`carry_i`, `value_i[31:1]`} and `carry_o` is `value_i[0]`.
- R6: With `amt_from_reg_i`=1 and `reg_amt_i`=0, every shift type gives `operand_o`=`value_i` and `carry_o`=`carry_i`.
- R7: With `amt_from_reg_i`=1 and `reg_amt_i` in 1..31, logical and arithmetic shifts behave as in R1 with amount `reg_amt_i`.
- R8: With `amt_from_reg_i`=1, a logical left or right shift by 32 gives operand 0, and `carry_o` is `value_i[0]` (left) or `value_i[31]` (right). Amounts from 33 to 255 give operand 0 and `carry_o`=0.
- R9: With `amt_from_reg_i`=1, an arithmetic right shift by 32 or more fills the operand with `value_i[31]` and sets `carry_o`=`value_i[31]`.
- R10: With `amt_from_reg_i`=1 and a nonzero `reg_amt_i`, a rotate uses only `reg_amt_i[4:0]`. When those bits are 0, the operand is `value_i` and `carry_o` is `value_i[31]`.
- R11: With `rot_imm_en_i`=1, the operand is `imm8_i`, zero-extended to 32 bits and rotated right by 2*`rot_i`.
- R12: With `rot_imm_en_i`=1, `carry_o` is `carry_i` when `rot_i`=0. For any other `rot_i`, it is bit 31 of the operand.
- R13: `rot_imm_en_i`=1 takes priority. `value_i`, `shift_type_i`, both amounts and `amt_from_reg_i` then have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 32 | Register value to shift |
| shift_type_i | input | 2 | Shift type (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| imm_amt_i | input | 5 | Amount encoded in the instruction |
| reg_amt_i | input | 8 | Amount taken from the low byte of a register |
| amt_from_reg_i | input | 1 | 1 selects `reg_amt_i`, 0 selects `imm_amt_i` |
| rot_imm_en_i | input | 1 | Select the rotated-constant operand |
| imm8_i | input | 8 | Eight-bit constant |
| rot_i | input | 4 | Rotate field; the constant rotates right by twice this value |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifter operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The unit holds no state. A wrong internal decision therefore shows up on `operand_o` or `carry_o` in the same evaluation as the input that triggers it, and the bench samples at the next half period. The faults most likely to slip through are in the amount decode: a zero immediate amount mapped to the wrong action, an off-by-one at the 32 boundary, or the rotate path masking the amount too early. Each of these alters only a few encodings, so the amounts 0, 1, 31, 32, 33 and 255 are applied under every shift type. Random vectors are applied as well.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_type_e;

  // what the output mux takes for the shifted-register operand
  typedef enum logic [1:0] {
    ACT_CORE = 2'd0,
    ACT_PASS = 2'd1,
    ACT_RRX  = 2'd2,
    ACT_ZERO = 2'd3
  } act_e;

endpackage

// File: rtl/sop_shift_core.sv
module sop_shift_core
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value_i,
  input  sh_type_e         type_i,
  input  logic [SH_W:0]    amt_i,    // 0..WIDTH
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  localparam logic [SH_W:0] FULL = (SH_W+1)'(WIDTH);

  logic [WIDTH:0]  left_ext;
  logic [WIDTH:0]  right_ext;
  logic [WIDTH:0]  arith_ext;
  logic [SH_W:0]   inv_amt;
  logic [WIDTH-1:0] rot_res;

  // one guard bit beyond the word catches the last bit shifted out
  assign left_ext  = {1'b0, value_i} << amt_i;
  assign right_ext = {value_i, 1'b0} >> amt_i;
  assign arith_ext = $unsigned($signed({value_i, 1'b0}) >>> amt_i);
  assign inv_amt   = FULL - amt_i;
  assign rot_res   = (value_i >> amt_i) | (value_i << inv_amt);

  always_comb begin
    unique case (type_i)
      SH_LSL: begin
        res_o   = left_ext[WIDTH-1:0];
        carry_o = left_ext[WIDTH];
      end
      SH_LSR: begin
        res_o   = right_ext[WIDTH:1];
        carry_o = right_ext[0];
      end
      SH_ASR: begin
        res_o   = arith_ext[WIDTH:1];
        carry_o = arith_ext[0];
      end
      default: begin
        res_o   = rot_res;
        carry_o = right_ext[0];
      end
    endcase
  end

endmodule

// File: rtl/sop_amount_decode.sv
module sop_amount_decode
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  sh_type_e         type_i,
  input  logic             from_reg_i,
  input  logic [SH_W-1:0]  imm_amt_i,
  input  logic [AMT_W-1:0] reg_amt_i,
  output act_e             act_o,
  output logic [SH_W:0]    amt_o
);

  localparam logic [SH_W:0]    FULL   = (SH_W+1)'(WIDTH);
  localparam logic [AMT_W-1:0] FULL_R = AMT_W'(WIDTH);

  logic [SH_W-1:0] reg_low;
  assign reg_low = reg_amt_i[SH_W-1:0];

  always_comb begin
    act_o = ACT_CORE;
    amt_o = {1'b0, imm_amt_i};
    if (!from_reg_i) begin
      if (imm_amt_i == '0) begin
        unique case (type_i)
          SH_LSL:         act_o = ACT_PASS;
          SH_LSR, SH_ASR: amt_o = FULL;
          default:        act_o = ACT_RRX;
        endcase
      end
    end else if (reg_amt_i == '0) begin
      act_o = ACT_PASS;
    end else begin
      unique case (type_i)
        SH_ROR: amt_o = (reg_low == '0) ? FULL : {1'b0, reg_low};
        SH_ASR: amt_o = (reg_amt_i >= FULL_R) ? FULL : reg_amt_i[SH_W:0];
        default: begin
          if (reg_amt_i > FULL_R) act_o = ACT_ZERO;
          else                    amt_o = reg_amt_i[SH_W:0];
        end
      endcase
    end
  end

endmodule

// File: rtl/sop_rot_imm.sv
module sop_rot_imm
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [IMM_W-1:0] imm8_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  logic [WIDTH-1:0] ext;
  logic [SH_W:0]    amt;
  logic             core_carry;

  assign ext = WIDTH'(imm8_i);
  assign amt = (SH_W+1)'({rot_i, 1'b0});

  sop_shift_core #(.WIDTH(WIDTH)) u_core (
    .value_i (ext),
    .type_i  (SH_ROR),
    .amt_i   (amt),
    .res_o   (res_o),
    .carry_o (core_carry)
  );

  // after a nonzero rotate, the core carry is the new top bit
  assign carry_o = (rot_i == '0) ? carry_i : core_carry;

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import sop_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic [1:0]       shift_type_i,
  input  logic [SH_W-1:0]  imm_amt_i,
  input  logic [AMT_W-1:0] reg_amt_i,
  input  logic             amt_from_reg_i,
  input  logic             rot_imm_en_i,
  input  logic [IMM_W-1:0] imm8_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] operand_o,
  output logic             carry_o
);

  sh_type_e         sh_type;
  act_e             act;
  logic [SH_W:0]    core_amt;
  logic [WIDTH-1:0] core_res;
  logic             core_carry;
  logic [WIDTH-1:0] rimm_res;
  logic             rimm_carry;

  assign sh_type = sh_type_e'(shift_type_i);

  sop_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .type_i     (sh_type),
    .from_reg_i (amt_from_reg_i),
    .imm_amt_i  (imm_amt_i),
    .reg_amt_i  (reg_amt_i),
    .act_o      (act),
    .amt_o      (core_amt)
  );

  sop_shift_core #(.WIDTH(WIDTH)) u_core (
    .value_i (value_i),
    .type_i  (sh_type),
    .amt_i   (core_amt),
    .res_o   (core_res),
    .carry_o (core_carry)
  );

  sop_rot_imm #(.WIDTH(WIDTH), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rimm (
    .imm8_i  (imm8_i),
    .rot_i   (rot_i),
    .carry_i (carry_i),
    .res_o   (rimm_res),
    .carry_o (rimm_carry)
  );

  always_comb begin
    if (rot_imm_en_i) begin
      operand_o = rimm_res;
      carry_o   = rimm_carry;
    end else begin
      unique case (act)
        ACT_PASS: begin
          operand_o = value_i;
          carry_o   = carry_i;
        end
        ACT_RRX: begin
          operand_o = {carry_i, value_i[WIDTH-1:1]};
          carry_o   = value_i[0];
        end
        ACT_ZERO: begin
          operand_o = '0;
          carry_o   = 1'b0;
        end
        default: begin
          operand_o = core_res;
          carry_o   = core_carry;
        end
      endcase
    end
  end

endmodule

module shifter_operand_unit_chk #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  localparam int SH_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] value_i,
  input logic [1:0]       shift_type_i,
  input logic [SH_W-1:0]  imm_amt_i,
  input logic [AMT_W-1:0] reg_amt_i,
  input logic             amt_from_reg_i,
  input logic             rot_imm_en_i,
  input logic [IMM_W-1:0] imm8_i,
  input logic [ROT_W-1:0] rot_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] operand_o,
  input logic             carry_o
);

  localparam logic [AMT_W-1:0] FULL_R = AMT_W'(WIDTH);

  logic known;
  logic imm_mode;
  logic reg_mode;
  assign known = !$isunknown({value_i, shift_type_i, imm_amt_i, reg_amt_i, amt_from_reg_i,
                              rot_imm_en_i, imm8_i, rot_i, carry_i, operand_o, carry_o});
  assign imm_mode = !rot_imm_en_i && !amt_from_reg_i;
  assign reg_mode = !rot_imm_en_i && amt_from_reg_i;

  always_comb begin
    if (known) begin
      if (imm_mode && imm_amt_i == '0 && shift_type_i == 2'd0)
        a_r2_imm_lsl_zero: assert (operand_o == value_i && carry_o == carry_i);
      if (imm_mode && imm_amt_i == '0 && shift_type_i == 2'd1)
        a_r3_imm_lsr_zero: assert (operand_o == '0 && carry_o == value_i[WIDTH-1]);
      if (imm_mode && imm_amt_i == '0 && shift_type_i == 2'd2)
        a_r4_imm_asr_zero: assert (operand_o == {WIDTH{value_i[WIDTH-1]}} && carry_o == value_i[WIDTH-1]);
      if (imm_mode && imm_amt_i == '0 && shift_type_i == 2'd3)
        a_r5_rrx: assert (operand_o == {carry_i, value_i[WIDTH-1:1]} && carry_o == value_i[0]);
      if (reg_mode && reg_amt_i == '0)
        a_r6_reg_zero_pass: assert (operand_o == value_i && carry_o == carry_i);
      if (reg_mode && !shift_type_i[1] && reg_amt_i > FULL_R)
        a_r8_reg_over_zero: assert (operand_o == '0 && !carry_o);
      if (reg_mode && shift_type_i == 2'd2 && reg_amt_i >= FULL_R)
        a_r9_reg_asr_fill: assert (operand_o == {WIDTH{value_i[WIDTH-1]}} && carry_o == value_i[WIDTH-1]);
      if (reg_mode && shift_type_i == 2'd3 && reg_amt_i != '0)
        a_r10_ror_keeps_ones: assert ($countones(operand_o) == $countones(value_i));
      if (rot_imm_en_i)
        a_r11_rimm_keeps_ones: assert ($countones(operand_o) == $countones(imm8_i));
      if (rot_imm_en_i && rot_i != '0)
        a_r12_rimm_carry_top: assert (carry_o == operand_o[WIDTH-1]);
    end
  end

endmodule

bind shifter_operand_unit shifter_operand_unit_chk #(
  .WIDTH(WIDTH), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
  .value_i        (value_i),
  .shift_type_i   (shift_type_i),
  .imm_amt_i      (imm_amt_i),
  .reg_amt_i      (reg_amt_i),
  .amt_from_reg_i (amt_from_reg_i),
  .rot_imm_en_i   (rot_imm_en_i),
  .imm8_i         (imm8_i),
  .rot_i          (rot_i),
  .carry_i        (carry_i),
  .operand_o      (operand_o),
  .carry_o        (carry_o)
);

// File: tb/shifter_operand_unit_test.sv
module shifter_operand_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] value_i = '0;
  logic [1:0]  shift_type_i = '0;
  logic [4:0]  imm_amt_i = '0;
  logic [7:0]  reg_amt_i = '0;
  logic        amt_from_reg_i = 1'b0;
  logic        rot_imm_en_i = 1'b0;
  logic [7:0]  imm8_i = '0;
  logic [3:0]  rot_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] operand_o;
  logic        carry_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shifter_operand_unit uut (
    .value_i(value_i), .shift_type_i(shift_type_i), .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i), .amt_from_reg_i(amt_from_reg_i), .rot_imm_en_i(rot_imm_en_i),
    .imm8_i(imm8_i), .rot_i(rot_i), .carry_i(carry_i),
    .operand_o(operand_o), .carry_o(carry_o)
  );

  // behavioural model: returns {carry, operand}
  function automatic logic [32:0] model(logic [31:0] v, logic [1:0] t, logic [4:0] ia,
                                        logic [7:0] ra, logic fr, logic re,
                                        logic [7:0] i8, logic [3:0] rt, logic ci);
    int n;
    int m;
    logic [63:0] w;
    logic [31:0] x;
    logic [31:0] r;
    if (re) begin
      n = 2 * int'(rt);
      x = {24'b0, i8};
      r = (n == 0) ? x : ((x >> n) | (x << (32 - n)));
      return {(n == 0) ? ci : r[31], r};
    end
    n = fr ? int'(ra) : int'(ia);
    if (n == 0) begin
      if (fr || t == 2'd0) return {ci, v};
      if (t == 2'd1) return {v[31], 32'b0};
      if (t == 2'd2) return {v[31], {32{v[31]}}};
      return {v[0], ci, v[31:1]};
    end
    case (t)
      2'd0: begin
        if (n > 32) return 33'b0;
        w = {32'b0, v} << n;
        return {w[32], w[31:0]};
      end
      2'd1: begin
        if (n > 32) return 33'b0;
        w = {v, 32'b0} >> n;
        return {w[31], w[63:32]};
      end
      2'd2: begin
        if (n >= 32) return {v[31], {32{v[31]}}};
        r = $signed(v) >>> n;
        return {v[n-1], r};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {v[31], v};
        r = (v >> m) | (v << (32 - m));
        return {v[m-1], r};
      end
    endcase
  endfunction

  function automatic string classify(logic [1:0] t, logic [4:0] ia, logic [7:0] ra,
                                     logic fr, logic re, logic [3:0] rt);
    if (re) return (rt == 0) ? "R12" : "R11";
    if (!fr) begin
      if (ia != 0) return "R1";
      case (t)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (ra == 0) return "R6";
    if (t == 2'd3) return "R10";
    if (t == 2'd2 && ra >= 32) return "R9";
    if (ra >= 32) return "R8";
    return "R7";
  endfunction

  task automatic apply(logic [31:0] v, logic [1:0] t, logic [4:0] ia, logic [7:0] ra,
                       logic fr, logic re, logic [7:0] i8, logic [3:0] rt, logic ci,
                       string tag = "");
    @(posedge clk);
    #1;
    value_i = v; shift_type_i = t; imm_amt_i = ia; reg_amt_i = ra;
    amt_from_reg_i = fr; rot_imm_en_i = re; imm8_i = i8; rot_i = rt; carry_i = ci;
    exp_q.push_back(model(v, t, ia, ra, fr, re, i8, rt, ci));
    tag_q.push_back((tag == "") ? classify(t, ia, ra, fr, re, rt) : tag);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [32:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({carry_o, operand_o} !== e) begin
        failures++;
        $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                 tg, operand_o, carry_o, e[31:0], e[32]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam int NB = 6;
  int bnd [NB] = '{0, 1, 31, 32, 33, 255};

  initial begin
    logic [31:0] vals [4];
    vals[0] = 32'h8000_0001;
    vals[1] = 32'h7FFF_FFFE;
    vals[2] = 32'hA5C3_0F96;
    vals[3] = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero inputs select a pass-through of zero (R2)
    apply('0, 2'd0, 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, 1'b0, "R2");

    // immediate amounts 0, 1, 31 for every type and both carry values (R1..R5)
    for (int t = 0; t < 4; t++)
      for (int vi = 0; vi < 4; vi++)
        for (int c = 0; c < 2; c++) begin
          apply(vals[vi], 2'(t), 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, 1'(c));
          apply(vals[vi], 2'(t), 5'd1, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, 1'(c));
          apply(vals[vi], 2'(t), 5'd31, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, 1'(c));
        end

    // register amounts at the boundaries (R6..R10)
    for (int t = 0; t < 4; t++)
      for (int b = 0; b < NB; b++)
        for (int vi = 0; vi < 4; vi++)
          apply(vals[vi], 2'(t), 5'd7, 8'(bnd[b]), 1'b1, 1'b0, 8'd0, 4'd0, 1'(vi & 1));

    // R10: multiples of 32 and masked low bits
    apply(32'h1234_5678, 2'd3, 5'd0, 8'd64, 1'b1, 1'b0, 8'd0, 4'd0, 1'b0, "R10");
    apply(32'h1234_5678, 2'd3, 5'd0, 8'd229, 1'b1, 1'b0, 8'd0, 4'd0, 1'b1, "R10");

    // rotated constant (R11, R12)
    for (int r = 0; r < 16; r++) begin
      apply(32'h0, 2'd0, 5'd0, 8'd0, 1'b0, 1'b1, 8'hFF, 4'(r), 1'b1);
      apply(32'h0, 2'd0, 5'd0, 8'd0, 1'b0, 1'b1, 8'h81, 4'(r), 1'b0);
    end

    // R13: rotated constant ignores the shift inputs
    apply(32'hFFFF_FFFF, 2'd2, 5'd0, 8'd255, 1'b1, 1'b1, 8'h3C, 4'd3, 1'b1, "R13");
    apply(32'h8000_0000, 2'd3, 5'd0, 8'd0, 1'b0, 1'b1, 8'h3C, 4'd3, 1'b0, "R13");
    apply(32'h5555_5555, 2'd1, 5'd9, 8'd40, 1'b1, 1'b1, 8'h00, 4'd0, 1'b1, "R13");

    // random mix
    for (int i = 0; i < 600; i++)
      apply($urandom, 2'($urandom), 5'($urandom), 8'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0), 8'($urandom), 4'($urandom), 1'($urandom));

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule